// File: doc/BRIEF.md
# Two-Memory Accumulator Processor Core

This block is a compact multicycle processor built around one 16-bit accumulator. Instructions and data sit in two physically separate memories. Each instruction is two bytes wide and is assembled, high byte first, from two consecutive reads of a byte-wide instruction memory. A 16-bit data memory supplies operands and receives stored results. A control state machine steps through initialisation, a three-cycle fetch, a decode cycle and one of several execute sequences. The sequence depends on the instruction's class: memory-operand arithmetic and load, accumulator-only operation, store, or branch.

An instruction holds a 4-bit opcode in bits [15:12] and a 12-bit operand field in bits [11:0]. The operand field is zero-extended to a data address or a branch target. The opcode values are:

| Opcode | Operation |
|---|---|
| 1 | ADD |
| 2 | SUB |
| 3 | AND |
| 4 | NOT |
| 5 | LOAD |
| 6 | STORE |
| 7 | branch if Z |
| 8 | branch if N |
| 9 | JUMP |

Every other opcode does nothing. Both memories have a one-cycle synchronous read. The data for an address appears on the read-data input in the cycle after the read strobe.

A testbench or a larger system attaches the two memories to the ports below. It loads a program at byte address 0 and releases reset. A jump to its own address is a convenient way to end a program.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, no memory strobe is active. Reset clears the program counter, accumulator and both flags. In the first cycle after release, the instruction memory is read at address 0.
- R2: An instruction is fetched as a read at PC (high byte, bits [15:12] opcode) and, in the very next cycle, a read at PC+1 (low byte). A non-branching instruction is followed by a fetch at PC+2.
- R3: ADD, SUB and AND (opcodes 1, 2, 3) combine the accumulator with the data word at the operand address, modulo 2^16. SUB computes accumulator minus memory word.
- R4: NOT (opcode 4) inverts every accumulator bit and makes no data memory access.
- R5: LOAD (opcode 5) reads the data word at the operand address into the accumulator. STORE (opcode 6) writes the accumulator to the operand address with a one-cycle write strobe. A cycle never carries more than one memory strobe.
- R6: N (result bit 15) and Z (result equal to zero) are updated only by ADD, SUB, AND, NOT and LOAD. Stores, branches, jumps and unused opcodes leave both flags unchanged.
- R7: Branch-if-Z (opcode 7) and branch-if-N (opcode 8) load the operand field into the PC when their flag is set. When the flag is clear, the next fetch is at PC+2.
- R8: JUMP (opcode 9) always loads the operand field into the PC.
- R9: Opcodes 0 and 10 to 15 change neither the accumulator nor the flags, and are followed by a fetch at PC+2.
- R10: From the start of one fetch to the start of the next, these cycle counts hold:
  - ADD, SUB, AND and LOAD take 6 cycles.
  - NOT, STORE, branches and JUMP take 5 cycles.
  - Unused opcodes take 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_rd_o | output | 1 | Instruction memory read strobe |
| imem_addr_o | output | 16 | Instruction byte address |
| imem_data_i | input | 8 | Instruction byte, valid the cycle after the strobe |
| dmem_rd_o | output | 1 | Data memory read strobe |
| dmem_wr_o | output | 1 | Data memory write strobe |
| dmem_addr_o | output | 16 | Data word address |
| dmem_wdata_o | output | 16 | Data written on a store |
| dmem_rdata_i | input | 16 | Data word, valid the cycle after the read strobe |

## Verification
A directed program runs first. It places a store straight after reset, which shows the cleared accumulator. It runs branches whose flags were set several instructions earlier, with stores in between, which separates flags that are held from flags that are recomputed. It also forces an addition that wraps to zero, a subtraction that goes negative, and both unused-opcode groups. Many random programs follow, with forward branch targets and data memory seeded with 0, 1, 0x8000 and 0xFFFF. They mix the instruction classes in orders the directed case does not reach. Each fetch address, fetch interval, load address and stored value is compared with an instruction-level model. A wrong operation, a flag that is not held, a missing PC increment or a wrong state count each shows up as a different failed comparison.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_AND = 4'h3,
    OP_NOT = 4'h4,
    OP_LD  = 4'h5,
    OP_ST  = 4'h6,
    OP_BZ  = 4'h7,
    OP_BN  = 4'h8,
    OP_JMP = 4'h9
  } opc_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_NOT,
    ALU_PASS
  } alu_op_e;

  typedef enum logic [3:0] {
    S_INIT,
    S_FHI,
    S_FLO,
    S_FWAIT,
    S_DEC,
    S_MRD,
    S_MWB,
    S_REG,
    S_ST,
    S_BR
  } state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o,
  output logic           neg_o,
  output logic           zero_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = b_i;
    endcase
  end

  assign neg_o  = y_o[W-1];
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opc_i,
  input  logic             flag_n_i,
  input  logic             flag_z_i,
  output logic             imem_rd_o,
  output logic             fetch_lo_o,
  output logic             ir_hi_en_o,
  output logic             ir_lo_en_o,
  output logic             pc_inc_o,
  output logic             pc_load_o,
  output logic             dmem_rd_o,
  output logic             dmem_wr_o,
  output logic             acc_en_o,
  output alu_op_e          alu_op_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_INIT;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_INIT:  state_d = S_FHI;
      S_FHI:   state_d = S_FLO;
      S_FLO:   state_d = S_FWAIT;
      S_FWAIT: state_d = S_DEC;
      S_DEC: begin
        case (opc_i)
          OP_ADD, OP_SUB, OP_AND, OP_LD: state_d = S_MRD;
          OP_NOT:                        state_d = S_REG;
          OP_ST:                         state_d = S_ST;
          OP_BZ, OP_BN, OP_JMP:          state_d = S_BR;
          default:                       state_d = S_FHI;
        endcase
      end
      S_MRD:   state_d = S_MWB;
      default: state_d = S_FHI;
    endcase
  end

  always_comb begin
    imem_rd_o  = (state_q == S_FHI) || (state_q == S_FLO);
    fetch_lo_o = (state_q == S_FLO);
    ir_hi_en_o = (state_q == S_FLO);
    ir_lo_en_o = (state_q == S_FWAIT);
    pc_inc_o   = (state_q == S_FWAIT);
    dmem_rd_o  = (state_q == S_MRD);
    dmem_wr_o  = (state_q == S_ST);
    acc_en_o   = (state_q == S_MWB) || (state_q == S_REG);
    pc_load_o  = 1'b0;
    if (state_q == S_BR) begin
      case (opc_i)
        OP_BZ:   pc_load_o = flag_z_i;
        OP_BN:   pc_load_o = flag_n_i;
        OP_JMP:  pc_load_o = 1'b1;
        default: pc_load_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (opc_i)
      OP_ADD:  alu_op_o = ALU_ADD;
      OP_SUB:  alu_op_o = ALU_SUB;
      OP_AND:  alu_op_o = ALU_AND;
      OP_NOT:  alu_op_o = ALU_NOT;
      default: alu_op_o = ALU_PASS;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int IBYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              imem_rd_o,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [IBYTE_W-1:0] imem_data_i,
  output logic              dmem_rd_o,
  output logic              dmem_wr_o,
  output logic [ADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  input  logic [DATA_W-1:0] dmem_rdata_i
);
  localparam int INSTR_B = 2;
  localparam int INSTR_W = INSTR_B * IBYTE_W;
  localparam int FIELD_W = INSTR_W - OPC_W;

  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  acc_q;
  logic               flag_n_q, flag_z_q;

  logic fetch_lo, ir_hi_en, ir_lo_en, pc_inc, pc_load, acc_en;
  logic [INSTR_B-1:0] ir_en;
  alu_op_e alu_op;
  logic [DATA_W-1:0] alu_y;
  logic alu_n, alu_z;
  logic [ADDR_W-1:0] field_ext;

  assign field_ext = {{(ADDR_W-FIELD_W){1'b0}}, ir_q[FIELD_W-1:0]};
  assign ir_en     = {ir_hi_en, ir_lo_en};

  acc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opc_i      (ir_q[INSTR_W-1 -: OPC_W]),
    .flag_n_i   (flag_n_q),
    .flag_z_i   (flag_z_q),
    .imem_rd_o  (imem_rd_o),
    .fetch_lo_o (fetch_lo),
    .ir_hi_en_o (ir_hi_en),
    .ir_lo_en_o (ir_lo_en),
    .pc_inc_o   (pc_inc),
    .pc_load_o  (pc_load),
    .dmem_rd_o  (dmem_rd_o),
    .dmem_wr_o  (dmem_wr_o),
    .acc_en_o   (acc_en),
    .alu_op_o   (alu_op)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op_i   (alu_op),
    .a_i    (acc_q),
    .b_i    (dmem_rdata_i),
    .y_o    (alu_y),
    .neg_o  (alu_n),
    .zero_o (alu_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_load) begin
      pc_q <= field_ext;
    end else if (pc_inc) begin
      pc_q <= pc_q + ADDR_W'(INSTR_B);
    end
  end

  // byte 1 is the high byte, read first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
    end else begin
      for (int b = 0; b < INSTR_B; b++) begin
        if (ir_en[b]) ir_q[b*IBYTE_W +: IBYTE_W] <= imem_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      flag_n_q <= 1'b0;
      flag_z_q <= 1'b0;
    end else if (acc_en) begin
      acc_q    <= alu_y;
      flag_n_q <= alu_n;
      flag_z_q <= alu_z;
    end
  end

  assign imem_addr_o  = fetch_lo ? pc_q + ADDR_W'(1) : pc_q;
  assign dmem_addr_o  = field_ext;
  assign dmem_wdata_o = acc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              imem_rd_o,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              dmem_rd_o,
  input logic              dmem_wr_o,
  input logic [ADDR_W-1:0] pc_q,
  input logic              flag_n_q,
  input logic              flag_z_q
);
  p_mem_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imem_rd_o, dmem_rd_o, dmem_wr_o}));

  p_lo_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(imem_rd_o) |=> imem_rd_o && (imem_addr_o == $past(imem_addr_o) + ADDR_W'(1)));

  p_two_reads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_rd_o && $past(imem_rd_o)) |=> !imem_rd_o);

  p_pc_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(imem_rd_o) |=> (pc_q == $past(imem_addr_o, 2) + ADDR_W'(1)));

  p_flags_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_wr_o |=> $stable({flag_n_q, flag_z_q}));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_rd_o   (imem_rd_o),
  .imem_addr_o (imem_addr_o),
  .dmem_rd_o   (dmem_rd_o),
  .dmem_wr_o   (dmem_wr_o),
  .pc_q        (pc_q),
  .flag_n_q    (flag_n_q),
  .flag_z_q    (flag_z_q)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        imem_rd, dmem_rd, dmem_wr;
  logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_q;
  logic [7:0]  imem_q;

  acc_cpu uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_rd_o    (imem_rd),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_q),
    .dmem_rd_o    (dmem_rd),
    .dmem_wr_o    (dmem_wr),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_q)
  );

  logic [7:0]  imem [256];
  logic [15:0] dmem [16];
  logic [15:0] mdl_dmem [16];

  always @(posedge clk) begin
    if (imem_rd) imem_q <= imem[imem_addr[7:0]];
    if (dmem_rd) dmem_q <= dmem[dmem_addr[3:0]];
    if (dmem_wr) dmem[dmem_addr[3:0]] <= dmem_wdata;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // instruction-level model, advanced at each fetch start
  logic [15:0] m_pc, m_acc, st_addr, st_data, rd_addr, lo_addr;
  logic        m_n, m_z;
  int          m_lat, cyc, last_hi, flag_age;
  string       pc_req, acc_req;
  bit          first, st_pend, rd_pend, prev_rd, expect_lo, done;

  always @(negedge clk) begin
    if (!rst_n) begin
      first = 1; st_pend = 0; rd_pend = 0; prev_rd = 0; expect_lo = 0;
      m_acc = '0; m_n = 0; m_z = 0; cyc = 0; last_hi = 0;
      acc_req = "R1"; pc_req = "R1"; flag_age = 0;
    end else begin
      cyc++;
      if (expect_lo) begin
        chk(imem_rd && imem_addr == lo_addr, "R2", "low byte fetch", {imem_rd, imem_addr}, {1'b1, lo_addr});
        expect_lo = 0;
      end else if (imem_rd && !prev_rd) begin
        logic [15:0] a, ins, v, nxt;
        logic [11:0] f;
        if (first) begin
          chk(imem_addr == 16'h0, "R1", "first fetch address", imem_addr, 0);
          chk(cyc == 1, "R1", "first fetch cycle", cyc, 1);
        end else begin
          chk(imem_addr == m_pc, pc_req, "fetch address", imem_addr, m_pc);
          chk(cyc - last_hi == m_lat, "R10", "instruction cycles", cyc - last_hi, m_lat);
          chk(!st_pend, "R5", "store missing", 0, 1);
          chk(!rd_pend, "R5", "operand read missing", 0, 1);
        end
        st_pend = 0; rd_pend = 0;
        first = 0; last_hi = cyc;
        a = imem_addr;
        expect_lo = 1; lo_addr = a + 16'd1;
        ins = {imem[a[7:0]], imem[lo_addr[7:0]]};
        f = ins[11:0];
        nxt = a + 16'd2; m_lat = 4; pc_req = "R2";
        case (ins[15:12])
          4'h1, 4'h2, 4'h3, 4'h5: begin
            v = mdl_dmem[f[3:0]];
            rd_pend = 1; rd_addr = {4'h0, f};
            case (ins[15:12])
              4'h1: m_acc = m_acc + v;
              4'h2: m_acc = m_acc - v;
              4'h3: m_acc = m_acc & v;
              default: m_acc = v;
            endcase
            acc_req = (ins[15:12] == 4'h5) ? "R5" : "R3";
            m_n = m_acc[15]; m_z = (m_acc == 0); flag_age = 1; m_lat = 6;
          end
          4'h4: begin
            m_acc = ~m_acc; acc_req = "R4";
            m_n = m_acc[15]; m_z = (m_acc == 0); flag_age = 1; m_lat = 5;
          end
          4'h6: begin
            st_pend = 1; st_addr = {4'h0, f}; st_data = m_acc;
            mdl_dmem[f[3:0]] = m_acc; m_lat = 5;
            if (flag_age == 1) flag_age = 2;
          end
          4'h7, 4'h8: begin
            if ((ins[15:12] == 4'h7) ? m_z : m_n) nxt = {4'h0, f};
            pc_req = (flag_age == 0) ? "R1" : (flag_age == 1) ? "R7" : "R6";
            if (flag_age == 1) flag_age = 2;
            m_lat = 5;
          end
          4'h9: begin
            nxt = {4'h0, f}; pc_req = "R8"; m_lat = 5;
            if (nxt == a) done = 1;
          end
          default: begin
            pc_req = "R9";
            if (flag_age == 1) flag_age = 2;
          end
        endcase
        m_pc = nxt;
      end
      if (dmem_rd) begin
        chk(rd_pend && dmem_addr == rd_addr, "R5", "operand read address", dmem_addr, rd_addr);
        rd_pend = 0;
      end
      if (dmem_wr) begin
        chk(st_pend && dmem_addr == st_addr, "R5", "store address", dmem_addr, st_addr);
        chk(dmem_wdata == st_data, acc_req, "store data", dmem_wdata, st_data);
        st_pend = 0;
      end
      prev_rd = imem_rd;
    end
  end

  function automatic logic [15:0] ins_w(input logic [3:0] op, input logic [11:0] f);
    return {op, f};
  endfunction

  task automatic put(input int slot, input logic [15:0] w);
    imem[(2*slot) % 256]     = w[15:8];
    imem[(2*slot + 1) % 256] = w[7:0];
  endtask

  task automatic run_prog(input string name);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!imem_rd && !dmem_rd && !dmem_wr, "R1", "strobes in reset", {imem_rd, dmem_rd, dmem_wr}, 0);
    for (int k = 0; k < 16; k++) mdl_dmem[k] = dmem[k];
    done = 0;
    #1 rst_n = 1;
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    chk(done, "R8", {"program halt: ", name}, done, 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic load_directed();
    dmem[0] = 16'h0000; dmem[1] = 16'hFFFF; dmem[2] = 16'h0001;
    dmem[3] = 16'h8000; dmem[4] = 16'h00F0;
    for (int k = 5; k < 16; k++) dmem[k] = 16'h1234 + 16'(k);
    for (int k = 0; k < 256; k++) imem[k] = 8'h00;
    put(0,  ins_w(4'h6, 12'd8));
    put(1,  ins_w(4'h7, 12'd8));
    put(2,  ins_w(4'h5, 12'd0));
    put(3,  ins_w(4'h6, 12'd9));
    put(4,  ins_w(4'h7, 12'd12));
    put(5,  ins_w(4'h6, 12'd10));
    put(6,  ins_w(4'h5, 12'd1));
    put(7,  ins_w(4'h1, 12'd2));
    put(8,  ins_w(4'h6, 12'd11));
    put(9,  ins_w(4'h8, 12'd22));
    put(10, ins_w(4'h2, 12'd2));
    put(11, ins_w(4'h8, 12'd26));
    put(12, ins_w(4'h6, 12'd12));
    put(13, ins_w(4'h4, 12'd0));
    put(14, ins_w(4'h6, 12'd13));
    put(15, ins_w(4'h5, 12'd4));
    put(16, ins_w(4'h3, 12'd1));
    put(17, ins_w(4'hF, 12'h123));
    put(18, ins_w(4'h0, 12'h000));
    put(19, ins_w(4'h6, 12'd14));
    put(20, ins_w(4'h9, 12'd44));
    put(21, ins_w(4'h6, 12'd15));
    put(22, ins_w(4'h2, 12'd3));
    put(23, ins_w(4'h6, 12'd7));
    put(24, ins_w(4'h9, 12'd48));
  endtask

  task automatic load_random();
    int len;
    len = 10 + int'($urandom % 30);
    for (int k = 0; k < 16; k++) begin
      case ($urandom % 6)
        0: dmem[k] = 16'h0000;
        1: dmem[k] = 16'hFFFF;
        2: dmem[k] = 16'h8000;
        3: dmem[k] = 16'h0001;
        default: dmem[k] = 16'($urandom);
      endcase
    end
    for (int k = 0; k < 256; k++) imem[k] = 8'h00;
    for (int i = 0; i < len - 1; i++) begin
      logic [3:0] op;
      logic [11:0] f;
      op = 4'($urandom % 16);
      if (op == 4'h7 || op == 4'h8 || op == 4'h9)
        f = 12'(2 * (i + 1 + int'($urandom % (len - 1 - i))));
      else if (op >= 4'h1 && op <= 4'h6)
        f = 12'($urandom % 16);
      else
        f = 12'($urandom);
      put(i, ins_w(op, f));
    end
    put(len - 1, ins_w(4'h9, 12'(2 * (len - 1))));
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    repeat (2) @(negedge clk);
    load_directed();
    run_prog("directed");
    for (int p = 0; p < 40; p++) begin
      load_random();
      run_prog("random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule